// File: doc/BRIEF.md
# Raster Region Labeler with Equivalence Table

The block takes a colour-quantised image one pixel at a time in raster order, top row first and left to right within a row. Each pixel is given a provisional region label. A pixel whose colour equals that of one of its four already-seen neighbours (left, up, up-left, up-right) reuses that neighbour's label. A pixel with no such neighbour opens a new label. Each label has an entry in a region table. The entry holds a parent pointer, a pixel weight, the colour and the coordinate of the pixel that opened the label. When two labels are found to belong to one region, the larger root is made to point at the smaller root, and its weight moves to the smaller one.

When the last pixel of the frame has been handled, a resolve pass walks the table from label 1 upward. After the pass, every entry names its root label directly. A region of exactly one pixel reads back as root 0, and its coordinate is sent out on a side stream. A downstream stage maps each provisional label from the label stream through the table read port to get its final region.

States: IDLE (after reset) goes to SCAN on `start`. SCAN accepts pixels. It goes to FIND after a pixel that matched a neighbour, or to RES_CHK after the last pixel of the frame. FIND follows parent pointers until both labels in play are roots, applies the weight and link update, and then goes back to SCAN, or on to RES_CHK if that pixel was the last one. RES_CHK handles one table entry per visit. It goes to RES_HOP for an entry that still points elsewhere, and to DONE once every allocated label has been visited. RES_HOP writes the two-step lookup back and returns to RES_CHK. DONE holds the table readable and goes to SCAN on `start`.

Top module: `lbl_raster_labeler`

## Requirements
- R1: After reset, `pix_ready`, `lab_valid`, `sing_valid`, `done` and `overflow` are all low, and no pixel is taken until `start` is pulsed.
- R2: A pixel with no matching neighbour receives the next unused label. Labels are handed out counting up from 1 in each frame. The new table entry has weight 1 and stores the pixel colour, which reads back unchanged on `rd_color`.
- R3: When labels 1 to 2^LABEL_W−1 are all in use and another new label is needed, `overflow` rises. That pixel and every later pixel of the frame are output with label 0, and the table receives no further updates. `overflow` stays high until the next `start`.
- R4: A neighbour matches when it lies inside the image and has exactly the same colour. The first matching neighbour in the order left, up, up-left, up-right supplies the pixel's label.
- R5: Each pixel that reuses a label adds one to the weight of that label's root. After resolve, a root's weight equals the number of pixels in its region.
- R6: When the up-right neighbour matches but carries a label different from the chosen one, the two roots are joined. The larger root then points at the smaller, the smaller root gets both weights plus the current pixel, and the larger root reads weight 0.
- R7: Each accepted pixel (`pix_valid` and `pix_ready` high at a clock edge) produces one `lab_valid` pulse in the next cycle. After a pixel that matched a neighbour, `pix_ready` is low in the next cycle while pointers are followed.
- R8: After resolve, `rd_root` for every allocated label is the smallest label of its connected same-colour set, and a root reads back itself.
- R9: After resolve, a root of weight 1 reads back `rd_root` = 0. During resolve its opening coordinate appears on `sing_x`/`sing_y` with `sing_valid`, in ascending label order and only while resolve runs.
- R10: `done` rises once resolve has visited every allocated label, and no pixel is taken while `done` is high. `rd_root`, `rd_weight` and `rd_color` show the entry at `rd_label` one cycle after it is presented.
- R11: A `start` pulse in IDLE or DONE begins a new frame: the label counter restarts at 1, `overflow` clears, and `pix_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (taken in IDLE or DONE) |
| pix_valid | input | 1 | Pixel present |
| pix_color | input | COLOR_W | Quantised pixel colour |
| pix_ready | output | 1 | Block can take a pixel this cycle |
| lab_valid | output | 1 | Provisional label present |
| lab_out | output | LABEL_W | Provisional label of the last accepted pixel (0 after overflow) |
| overflow | output | 1 | Label table exhausted in this frame |
| sing_valid | output | 1 | One-pixel region coordinate present |
| sing_x | output | XW | Column of a one-pixel region |
| sing_y | output | YW | Row of a one-pixel region |
| done | output | 1 | Resolve finished, table readable |
| rd_label | input | LABEL_W | Table read address |
| rd_root | output | LABEL_W | Resolved root of the addressed label (0 for one-pixel regions) |
| rd_weight | output | WT_W | Weight of the addressed entry |
| rd_color | output | COLOR_W | Colour stored with the addressed entry |

## Verification
The bench builds images that each stress a different path. A U-shaped stroke and a checkerboard only join through the up-right comparison. A design that skipped that comparison, or linked the smaller root under the larger, would report two roots for one shape, or a root that is not the minimum label. Isolated dots at the corners and edges check that positions outside the image never match: a wrapped column index would merge a dot with a pixel from the opposite edge and lose its one-pixel report. An image with all colours distinct runs out of labels partway through the frame, which checks that labels become 0 at exactly the right pixel and that the table stays frozen afterwards. Random two- and three-colour images build pointer chains several steps long, which a resolve pass that reads only one level would leave unflattened.

// File: rtl/lbl_pkg.sv
`timescale 1ns/1ps
package lbl_pkg;

    // Controller states of the raster labeler
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SCAN    = 3'd1,
        ST_FIND    = 3'd2,
        ST_RES_CHK = 3'd3,
        ST_RES_HOP = 3'd4,
        ST_DONE    = 3'd5
    } lbl_state_e;

    // Neighbour slot numbering; lower slot wins when several match
    localparam int NB_LEFT = 0;
    localparam int NB_UP   = 1;
    localparam int NB_UL   = 2;
    localparam int NB_UR   = 3;
    localparam int NB_NUM  = 4;

endpackage

// File: rtl/lbl_linebuf.sv
`timescale 1ns/1ps
// One row of labels and colours, updated in place. Entries left of the
// current column hold the current row, the rest hold the row above.
module lbl_linebuf #(
    parameter int IMG_W   = 8,
    parameter int LABEL_W = 4,
    parameter int COLOR_W = 8,
    parameter int XW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [XW-1:0]      col_x,
    input  logic [LABEL_W-1:0] wr_lab,
    input  logic [COLOR_W-1:0] wr_col,
    output logic [LABEL_W-1:0] left_lab,
    output logic [COLOR_W-1:0] left_col,
    output logic [LABEL_W-1:0] ul_lab,
    output logic [COLOR_W-1:0] ul_col,
    output logic [LABEL_W-1:0] up_lab,
    output logic [COLOR_W-1:0] up_col,
    output logic [LABEL_W-1:0] ur_lab,
    output logic [COLOR_W-1:0] ur_col
);

    localparam logic [XW-1:0] LAST_X = XW'(IMG_W - 1);

    logic [LABEL_W-1:0] row_lab [IMG_W];
    logic [COLOR_W-1:0] row_col [IMG_W];
    logic [XW-1:0]      nx;

    // Column to the right, held at the edge (validity is judged by the caller)
    assign nx = (col_x == LAST_X) ? col_x : col_x + XW'(1);

    assign up_lab = row_lab[col_x];
    assign up_col = row_col[col_x];
    assign ur_lab = row_lab[nx];
    assign ur_col = row_col[nx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            row_lab[col_x] <= wr_lab;
            row_col[col_x] <= wr_col;
        end
    end

    // Left is the pixel just written; up-left is what sat above it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_lab <= '0;
            left_col <= '0;
            ul_lab   <= '0;
            ul_col   <= '0;
        end else if (wr_en) begin
            left_lab <= wr_lab;
            left_col <= wr_col;
            ul_lab   <= row_lab[col_x];
            ul_col   <= row_col[col_x];
        end
    end

endmodule

// File: rtl/lbl_match.sv
`timescale 1ns/1ps
// Colour comparison against the four causal neighbours and label choice.
module lbl_match
    import lbl_pkg::*;
#(
    parameter int LABEL_W = 4,
    parameter int COLOR_W = 8
) (
    input  logic [COLOR_W-1:0] pix_col,
    input  logic               nb_ok  [NB_NUM],
    input  logic [LABEL_W-1:0] nb_lab [NB_NUM],
    input  logic [COLOR_W-1:0] nb_col [NB_NUM],
    output logic               hit,
    output logic [LABEL_W-1:0] sel_lab,
    output logic               need_merge,
    output logic [LABEL_W-1:0] mrg_lab
);

    logic [NB_NUM-1:0] same;

    for (genvar k = 0; k < NB_NUM; k++) begin : g_cmp
        assign same[k] = nb_ok[k] && (nb_col[k] == pix_col);
    end

    always_comb begin
        hit     = 1'b0;
        sel_lab = '0;
        for (int k = 0; k < NB_NUM; k++) begin
            if (!hit && same[k]) begin
                hit     = 1'b1;
                sel_lab = nb_lab[k];
            end
        end
        // Only the up-right pixel can belong to a set not yet joined to the choice
        need_merge = same[NB_UR] && (nb_lab[NB_UR] != sel_lab);
        mrg_lab    = nb_lab[NB_UR];
    end

endmodule

// File: rtl/lbl_raster_labeler.sv
`timescale 1ns/1ps
module lbl_raster_labeler
    import lbl_pkg::*;
#(
    parameter  int IMG_W   = 8,
    parameter  int IMG_H   = 6,
    parameter  int COLOR_W = 8,
    parameter  int LABEL_W = 4,
    localparam int XW      = (IMG_W > 1) ? $clog2(IMG_W) : 1,
    localparam int YW      = (IMG_H > 1) ? $clog2(IMG_H) : 1,
    localparam int WT_W    = $clog2(IMG_W * IMG_H + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               pix_valid,
    input  logic [COLOR_W-1:0] pix_color,
    output logic               pix_ready,
    output logic               lab_valid,
    output logic [LABEL_W-1:0] lab_out,
    output logic               overflow,
    output logic               sing_valid,
    output logic [XW-1:0]      sing_x,
    output logic [YW-1:0]      sing_y,
    output logic               done,
    input  logic [LABEL_W-1:0] rd_label,
    output logic [LABEL_W-1:0] rd_root,
    output logic [WT_W-1:0]    rd_weight,
    output logic [COLOR_W-1:0] rd_color
);

    localparam int              CAP    = 1 << LABEL_W;
    localparam int              NW     = LABEL_W + 1;
    localparam logic [NW-1:0]   FULL_N = NW'(CAP);
    localparam logic [XW-1:0]   LAST_X = XW'(IMG_W - 1);
    localparam logic [YW-1:0]   LAST_Y = YW'(IMG_H - 1);

    lbl_state_e state_q, state_d;

    // Scan position and label counter
    logic [XW-1:0]      x_q;
    logic [YW-1:0]      y_q;
    logic [NW-1:0]      next_q;
    logic               ovf_q;
    // Root search
    logic [LABEL_W-1:0] fa_q, fb_q;
    logic               last_q;
    // Resolve walk
    logic [NW-1:0]      e_q;
    logic [LABEL_W-1:0] t_q;

    // Region table
    logic [LABEL_W-1:0] t_idx [CAP];
    logic [WT_W-1:0]    t_wt  [CAP];
    logic [COLOR_W-1:0] t_col [CAP];
    logic [XW-1:0]      t_x   [CAP];
    logic [YW-1:0]      t_y   [CAP];

    // Neighbourhood
    logic               nb_ok  [NB_NUM];
    logic [LABEL_W-1:0] nb_lab [NB_NUM];
    logic [COLOR_W-1:0] nb_col [NB_NUM];
    logic               hit, need_merge;
    logic [LABEL_W-1:0] sel_lab, mrg_lab;

    logic               accept, at_last, full;
    logic [LABEL_W-1:0] cur_lab, new_lab, hi_lab, lo_lab, e_lab;
    logic               root_a, root_b, res_end;

    assign pix_ready = (state_q == ST_SCAN);
    assign overflow  = ovf_q;
    assign accept    = pix_ready && pix_valid;
    assign at_last   = (x_q == LAST_X) && (y_q == LAST_Y);
    assign full      = (next_q == FULL_N);
    assign new_lab   = next_q[LABEL_W-1:0];
    assign root_a    = (t_idx[fa_q] == '0);
    assign root_b    = (t_idx[fb_q] == '0);
    assign hi_lab    = (fa_q > fb_q) ? fa_q : fb_q;
    assign lo_lab    = (fa_q > fb_q) ? fb_q : fa_q;
    assign e_lab     = e_q[LABEL_W-1:0];
    assign res_end   = (e_q == next_q);

    assign cur_lab = (ovf_q || (!hit && full)) ? '0 :
                     (hit ? sel_lab : new_lab);

    assign nb_ok[NB_LEFT] = (x_q != '0);
    assign nb_ok[NB_UP]   = (y_q != '0);
    assign nb_ok[NB_UL]   = (x_q != '0) && (y_q != '0);
    assign nb_ok[NB_UR]   = (y_q != '0) && (x_q != LAST_X);

    lbl_linebuf #(
        .IMG_W   (IMG_W),
        .LABEL_W (LABEL_W),
        .COLOR_W (COLOR_W),
        .XW      (XW)
    ) u_linebuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .col_x    (x_q),
        .wr_lab   (cur_lab),
        .wr_col   (pix_color),
        .left_lab (nb_lab[NB_LEFT]),
        .left_col (nb_col[NB_LEFT]),
        .ul_lab   (nb_lab[NB_UL]),
        .ul_col   (nb_col[NB_UL]),
        .up_lab   (nb_lab[NB_UP]),
        .up_col   (nb_col[NB_UP]),
        .ur_lab   (nb_lab[NB_UR]),
        .ur_col   (nb_col[NB_UR])
    );

    lbl_match #(
        .LABEL_W (LABEL_W),
        .COLOR_W (COLOR_W)
    ) u_match (
        .pix_col    (pix_color),
        .nb_ok      (nb_ok),
        .nb_lab     (nb_lab),
        .nb_col     (nb_col),
        .hit        (hit),
        .sel_lab    (sel_lab),
        .need_merge (need_merge),
        .mrg_lab    (mrg_lab)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SCAN;
            ST_SCAN: begin
                if (accept) begin
                    if (hit && !ovf_q) state_d = ST_FIND;
                    else if (at_last)  state_d = ST_RES_CHK;
                end
            end
            ST_FIND: begin
                if (root_a && root_b) state_d = last_q ? ST_RES_CHK : ST_SCAN;
            end
            ST_RES_CHK: begin
                if (res_end)                state_d = ST_DONE;
                else if (t_idx[e_lab] != '0) state_d = ST_RES_HOP;
            end
            ST_RES_HOP: state_d = ST_RES_CHK;
            ST_DONE:    if (start) state_d = ST_SCAN;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            next_q <= NW'(1);
            ovf_q  <= 1'b0;
            fa_q   <= '0;
            fb_q   <= '0;
            last_q <= 1'b0;
            e_q    <= NW'(1);
            t_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        x_q    <= '0;
                        y_q    <= '0;
                        next_q <= NW'(1);
                        ovf_q  <= 1'b0;
                        e_q    <= NW'(1);
                    end
                end
                ST_SCAN: begin
                    if (accept) begin
                        if (x_q == LAST_X) begin
                            x_q <= '0;
                            y_q <= y_q + YW'(1);
                        end else begin
                            x_q <= x_q + XW'(1);
                        end
                        last_q <= at_last;
                        if (!ovf_q) begin
                            if (hit) begin
                                fa_q <= sel_lab;
                                fb_q <= need_merge ? mrg_lab : sel_lab;
                            end else if (full) begin
                                ovf_q <= 1'b1;
                            end else begin
                                next_q <= next_q + NW'(1);
                            end
                        end
                    end
                end
                ST_FIND: begin
                    if (!root_a) fa_q <= t_idx[fa_q];
                    if (!root_b) fb_q <= t_idx[fb_q];
                end
                ST_RES_CHK: begin
                    if (!res_end) begin
                        if (t_idx[e_lab] != '0) t_q <= t_idx[e_lab];
                        else                    e_q <= e_q + NW'(1);
                    end
                end
                ST_RES_HOP: e_q <= e_q + NW'(1);
                default: ;
            endcase
        end
    end

    // Region table updates
    always_ff @(posedge clk) begin
        unique case (state_q)
            ST_SCAN: begin
                if (accept && !ovf_q && !hit && !full) begin
                    t_idx[new_lab] <= '0;
                    t_wt[new_lab]  <= WT_W'(1);
                    t_col[new_lab] <= pix_color;
                    t_x[new_lab]   <= x_q;
                    t_y[new_lab]   <= y_q;
                end
            end
            ST_FIND: begin
                if (root_a && root_b) begin
                    if (fa_q == fb_q) begin
                        t_wt[fa_q] <= t_wt[fa_q] + WT_W'(1);
                    end else begin
                        t_idx[hi_lab] <= lo_lab;
                        t_wt[lo_lab]  <= t_wt[lo_lab] + t_wt[hi_lab] + WT_W'(1);
                        t_wt[hi_lab]  <= '0;
                    end
                end
            end
            ST_RES_CHK: begin
                if (!res_end && (t_idx[e_lab] == '0) && (t_wt[e_lab] != WT_W'(1)))
                    t_idx[e_lab] <= e_lab;
            end
            ST_RES_HOP: t_idx[e_lab] <= t_idx[t_q];
            default: ;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lab_valid  <= 1'b0;
            lab_out    <= '0;
            sing_valid <= 1'b0;
            sing_x     <= '0;
            sing_y     <= '0;
            done       <= 1'b0;
            rd_root    <= '0;
            rd_weight  <= '0;
            rd_color   <= '0;
        end else begin
            lab_valid  <= accept;
            if (accept) lab_out <= cur_lab;
            sing_valid <= (state_q == ST_RES_CHK) && !res_end &&
                          (t_idx[e_lab] == '0) && (t_wt[e_lab] == WT_W'(1));
            sing_x     <= t_x[e_lab];
            sing_y     <= t_y[e_lab];
            done       <= (state_d == ST_DONE);
            rd_root    <= t_idx[rd_label];
            rd_weight  <= t_wt[rd_label];
            rd_color   <= t_col[rd_label];
        end
    end

endmodule

// File: rtl/lbl_raster_labeler_chk.sv
`timescale 1ns/1ps
module lbl_raster_labeler_chk #(
    parameter int LABEL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               pix_valid,
    input logic               pix_ready,
    input logic               lab_valid,
    input logic [LABEL_W-1:0] lab_out,
    input logic               overflow,
    input logic               sing_valid,
    input logic               done
);

    // R7: a label appears only in the cycle after an accepted pixel
    p_label_follows_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lab_valid |-> $past(pix_valid && pix_ready));

    // R3: once the table is exhausted every label is 0
    p_ovf_zero_label_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lab_valid && overflow) |-> (lab_out == '0));

    // R3: exhaustion is held until a new frame starts
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    // R10: no pixel intake or label output while the table is readable
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!pix_ready && !lab_valid));

    // R9: one-pixel reports only during resolve
    p_sing_in_resolve_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sing_valid |-> (!pix_ready && !done));

    // R8: resolve finishes with no pixel being taken
    p_done_after_resolve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!pix_ready));

endmodule

bind lbl_raster_labeler lbl_raster_labeler_chk #(.LABEL_W(LABEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .lab_valid  (lab_valid),
    .lab_out    (lab_out),
    .overflow   (overflow),
    .sing_valid (sing_valid),
    .done       (done)
);

// File: tb/sim_lbl_raster_labeler.sv
`timescale 1ns/1ps
module sim_lbl_raster_labeler;

    localparam int W   = 8;
    localparam int H   = 6;
    localparam int CW  = 8;
    localparam int LW  = 4;
    localparam int CAP = 1 << LW;
    localparam int XW  = 3;
    localparam int YW  = 3;
    localparam int WTW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [CW-1:0] pix_color = '0;
    logic          pix_ready, lab_valid, overflow, sing_valid, done;
    logic [LW-1:0] lab_out, rd_root;
    logic [LW-1:0] rd_label = '0;
    logic [XW-1:0] sing_x;
    logic [YW-1:0] sing_y;
    logic [WTW-1:0] rd_weight;
    logic [CW-1:0] rd_color;

    always #4 clk = ~clk;

    lbl_raster_labeler #(.IMG_W(W), .IMG_H(H), .COLOR_W(CW), .LABEL_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
        .pix_color(pix_color), .pix_ready(pix_ready), .lab_valid(lab_valid),
        .lab_out(lab_out), .overflow(overflow), .sing_valid(sing_valid),
        .sing_x(sing_x), .sing_y(sing_y), .done(done), .rd_label(rd_label),
        .rd_root(rd_root), .rd_weight(rd_weight), .rd_color(rd_color)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit running = 1'b0;

    // Reference model state
    int img  [H][W];
    int labm [H][W];
    bit hitm [H][W];
    int par [CAP];
    int wtm [CAP];
    int colm[CAP];
    int pxm [CAP];
    int pym [CAP];
    int nl;
    // Expected streams
    int    q_lab[$];
    int    q_ovf[$];
    string q_tag[$];
    int    q_sx[$];
    int    q_sy[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "R10", "watchdog expired", cyc, 100000);
            report();
        end
    end

    // Compare the output streams against the model on every clock
    always @(negedge clk) begin
        if (running && lab_valid) begin
            if (q_lab.size() == 0) chk(1'b0, "R7", "unexpected label", int'(lab_out), -1);
            else begin
                chk(int'(lab_out) == q_lab[0], q_tag[0], "label", int'(lab_out), q_lab[0]);
                chk(int'(overflow) == q_ovf[0], "R3", "overflow flag", int'(overflow), q_ovf[0]);
                void'(q_lab.pop_front()); void'(q_ovf.pop_front()); void'(q_tag.pop_front());
            end
        end
        if (running && sing_valid) begin
            if (q_sx.size() == 0) chk(1'b0, "R9", "unexpected singleton", int'(sing_x), -1);
            else begin
                chk(int'(sing_x) == q_sx[0], "R9", "singleton x", int'(sing_x), q_sx[0]);
                chk(int'(sing_y) == q_sy[0], "R9", "singleton y", int'(sing_y), q_sy[0]);
                void'(q_sx.pop_front()); void'(q_sy.pop_front());
            end
        end
    end

    function automatic int findr(input int l);
        int r = l;
        while (par[r] != r) r = par[r];
        return r;
    endfunction

    task automatic build(input int kind, input int seed);
        int unsigned s = seed;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                s = s * 1103515245 + 12345;
                case (kind)
                    0: img[y][x] = 5;
                    1: img[y][x] = (((x == 1 || x == 5) && y < 5) || (y == 4 && x >= 1 && x <= 5)) ? 9 : 2;
                    2: img[y][x] = int'((s >> 16) % 2);
                    3: img[y][x] = int'((s >> 16) % 3);
                    4: img[y][x] = y * W + x;
                    5: img[y][x] = ((x == 0 && y == 0) || (x == 7 && y == 5) || (x == 3 && y == 2) ||
                                    (x == 7 && y == 1) || (x == 0 && y == 4)) ? 7 : 1;
                    default: img[y][x] = (x + y) % 2;
                endcase
            end
    endtask

    task automatic model(input bit first_frame);
        bit ovf = 1'b0;
        nl = 1;
        for (int i = 0; i < CAP; i++) begin par[i] = i; wtm[i] = 0; end
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                int c = img[y][x];
                bit ok[4];
                int nb[4];
                bit hit = 1'b0;
                int sel = 0;
                int lab;
                string tag;
                ok[0] = (x > 0) && img[y][(x > 0) ? x-1 : 0] == c;
                nb[0] = labm[y][(x > 0) ? x-1 : 0];
                ok[1] = (y > 0) && img[(y > 0) ? y-1 : 0][x] == c;
                nb[1] = labm[(y > 0) ? y-1 : 0][x];
                ok[2] = (x > 0) && (y > 0) && img[(y > 0) ? y-1 : 0][(x > 0) ? x-1 : 0] == c;
                nb[2] = labm[(y > 0) ? y-1 : 0][(x > 0) ? x-1 : 0];
                ok[3] = (y > 0) && (x < W-1) && img[(y > 0) ? y-1 : 0][(x < W-1) ? x+1 : x] == c;
                nb[3] = labm[(y > 0) ? y-1 : 0][(x < W-1) ? x+1 : x];
                for (int k = 0; k < 4; k++) if (!hit && ok[k]) begin hit = 1'b1; sel = nb[k]; end
                hitm[y][x] = hit && !ovf;
                if (ovf) begin lab = 0; tag = "R3"; end
                else if (hit) begin
                    int a = findr(sel);
                    int b = (ok[3] && nb[3] != sel) ? findr(nb[3]) : a;
                    lab = sel; tag = "R4";
                    if (a == b) wtm[a] += 1;
                    else begin
                        int lo = (a < b) ? a : b;
                        int hi = (a < b) ? b : a;
                        par[hi] = lo; wtm[lo] += wtm[hi] + 1; wtm[hi] = 0;
                    end
                end else if (nl == CAP) begin
                    ovf = 1'b1; lab = 0; tag = "R3";
                end else begin
                    lab = nl; tag = "R2";
                    wtm[nl] = 1; colm[nl] = c; pxm[nl] = x; pym[nl] = y; nl++;
                end
                if (x == 0 && y == 0 && !first_frame) tag = "R11";
                labm[y][x] = lab;
                q_lab.push_back(lab); q_ovf.push_back(int'(ovf)); q_tag.push_back(tag);
            end
        for (int l = 1; l < nl; l++)
            if (par[l] == l && wtm[l] == 1) begin q_sx.push_back(pxm[l]); q_sy.push_back(pym[l]); end
    endtask

    task automatic run_frame(input int kind, input int seed, input bit first_frame);
        build(kind, seed);
        model(first_frame);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(pix_ready == 1'b1, "R11", "ready after start", int'(pix_ready), 1);
        chk(overflow == 1'b0, "R11", "overflow cleared", int'(overflow), 0);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                pix_valid = 1'b1;
                pix_color = CW'(img[y][x]);
                while (!pix_ready) @(negedge clk);
                @(negedge clk);
                chk(lab_valid == 1'b1, "R7", "label one cycle after accept", int'(lab_valid), 1);
                if (hitm[y][x])
                    chk(pix_ready == 1'b0, "R7", "stall after matched pixel", int'(pix_ready), 0);
            end
        pix_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(q_lab.size() == 0, "R7", "labels outstanding", q_lab.size(), 0);
        chk(q_sx.size() == 0, "R9", "singletons outstanding", q_sx.size(), 0);
        chk(pix_ready == 1'b0, "R10", "no intake when done", int'(pix_ready), 0);
        for (int l = 1; l < nl; l++) begin
            int r = findr(l);
            bit single = (r == l) && (wtm[l] == 1);
            rd_label = LW'(l);
            @(negedge clk);
            chk(int'(rd_root) == (single ? 0 : r), single ? "R9" : "R8", "root", int'(rd_root), single ? 0 : r);
            chk(int'(rd_weight) == wtm[l], (r == l) ? "R5" : "R6", "weight", int'(rd_weight), wtm[l]);
            chk(int'(rd_color) == colm[l], "R2", "colour", int'(rd_color), colm[l]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_ready == 1'b0, "R1", "ready after reset", int'(pix_ready), 0);
        chk(lab_valid == 1'b0, "R1", "label valid after reset", int'(lab_valid), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);
        chk(sing_valid == 1'b0, "R1", "singleton after reset", int'(sing_valid), 0);
        pix_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(lab_valid == 1'b0, "R1", "pixel taken before start", int'(lab_valid), 0);
        pix_valid = 1'b0;
        running = 1'b1;
        run_frame(0, 1, 1'b1);
        run_frame(1, 2, 1'b0);
        run_frame(5, 3, 1'b0);
        run_frame(6, 4, 1'b0);
        run_frame(2, 11, 1'b0);
        run_frame(2, 77, 1'b0);
        run_frame(3, 5, 1'b0);
        run_frame(4, 6, 1'b0);
        run_frame(0, 7, 1'b0);
        report();
    end

endmodule